// File: doc/BRIEF.md
# Split-Byte Converter Read Controller

This block is a synchronous host-side sequencer for an external sampling converter. The converter reports a 10-bit result over an 8-bit bus. On a start request the controller drives a conversion-start strobe low. It then waits for the converter's busy line to rise and fall again. After that it fetches the result with two chip-select/read cycles: the upper eight bits first, then the two low bits, which arrive on bus lines 7 and 6. It then presents the assembled word with a single-cycle valid pulse.

An 8-bit mode fetches only the upper byte. This works because the converter restarts its read order at every new conversion. A guard interval after the last read holds off the next conversion start. A timeout in both busy-wait phases abandons a conversion that never completes and raises an error flag. The busy input passes through a synchronizer. The active-low reset asserts asynchronously and is released synchronously inside the block.

Top module: `adc_split_host`

## Requirements
- R1: While and after reset, conv_n, cs_n and rd_n are high, result_valid is low and timeout_err is low.
- R2: A start_req seen while idle drives conv_n low for exactly START_W clock cycles. No read strobe is active while conv_n is low.
- R3: A read strobe is issued only after busy_in has been seen high and then low, and never while busy_in is high.
- R4: cs_n and rd_n fall and rise together. Each read holds them low for exactly STROBE_W cycles. In 10-bit mode the two reads are separated by exactly GAP_W cycles with the strobes high.
- R5: In 10-bit mode the first read supplies result[9:2] from data_in[7:0]. The second read supplies result[1:0] from data_in[7:6], and data_in[5:0] of the second read has no effect on the result.
- R6: result_valid is high for exactly one cycle per completed conversion: the first cycle after the final strobe returns high.
- R7: When mode8 is high at the accepted start_req, only one read is issued and result equals {upper byte, 2'b00}. The next 10-bit conversion again starts with the upper byte.
- R8: While start_req is held high, the next conversion-start falling edge comes exactly GUARD_W+2 cycles after the last strobe of the previous conversion returns high, and never fewer than GUARD_W+1. A start_req during a conversion does not cause an extra start pulse.
- R9: If busy_in is not seen high within TIMEOUT_W cycles after the start pulse ends, or not seen low within TIMEOUT_W cycles after it rose, the controller returns to idle without any read or valid pulse. It then holds timeout_err high until the next start_req is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request a conversion (accepted when idle) |
| mode8 | input | 1 | 1: read the upper byte only |
| busy_in | input | 1 | Converter busy indication (asynchronous) |
| data_in | input | 8 | Converter data bus |
| conv_n | output | 1 | Active-low conversion-start strobe |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| result | output | 10 | Assembled conversion result |
| result_valid | output | 1 | One-cycle result qualifier |
| timeout_err | output | 1 | Busy timeout flag, cleared by the next accepted start |

## Verification
The assertions run on every cycle. They check that chip select and read move together and hold each low phase for the programmed width. They also check that no strobe overlaps the conversion-start pulse or a high busy line, that the valid pulse lasts one cycle, that the guard interval is kept before each start edge, and that no read occurs while the error flag is set. The directed scenarios are the only place where the data path is exercised: the byte order, taking the low bits from bus lines 7 and 6 while the lines below are junk, the single read and zero fill of 8-bit mode, and the restart of the read order after it. The scenarios also cover the start pulse width, the exact inter-read gap, start requests held through a conversion, and both timeout exits, including the error clearing on the next start.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_RD_HI,
    ST_GAP,
    ST_RD_LO,
    ST_DONE,
    ST_GUARD
  } host_state_e;

  function automatic int unsigned max_of5(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d,
                                          input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= d;
          for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
          end
        end
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (!zero) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_host_asm.sv
module adc_host_asm #(
  parameter int BUS_W = 8,
  parameter int LOW_W = 2,
  localparam int RES_W = BUS_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_hi,
  input  logic             cap_lo,
  input  logic             fin8,
  input  logic [BUS_W-1:0] data_in,
  output logic [RES_W-1:0] result,
  output logic             valid
);

  logic [BUS_W-1:0] hi_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;
  logic             res_en;
  logic             valid_q;

  always_comb begin
    res_en = cap_lo | fin8;
    if (fin8) begin
      res_d = {data_in, {LOW_W{1'b0}}};
    end else begin
      res_d = {hi_q, data_in[BUS_W-1 -: LOW_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (cap_hi) begin
      hi_q <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= res_en;
    end
  end

  assign result = res_q;
  assign valid  = valid_q;

endmodule

// File: rtl/adc_host_fsm.sv
module adc_host_fsm
  import adc_host_pkg::*;
#(
  parameter int START_W   = 3,
  parameter int STROBE_W  = 4,
  parameter int GAP_W     = 2,
  parameter int GUARD_W   = 10,
  parameter int TIMEOUT_W = 200,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             mode8,
  input  logic             busy_s,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cap_hi,
  output logic             cap_lo,
  output logic             fin8,
  output logic             conv_n,
  output logic             cs_n,
  output logic             rd_n,
  output logic             timeout_err
);

  host_state_e st_q, st_d;
  logic        mode_q;
  logic        mode_en;
  logic        err_q, err_d;
  logic        err_set, err_clr;
  logic        conv_n_q, cs_n_q, rd_n_q;
  logic        strobe_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    fin8     = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    mode_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          st_d     = ST_START;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(START_W - 1);
          err_clr  = 1'b1;
          mode_en  = 1'b1;
        end
      end
      ST_START: begin
        if (tmr_zero) begin
          st_d     = ST_WAIT_HI;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TIMEOUT_W - 1);
        end
      end
      ST_WAIT_HI: begin
        if (busy_s) begin
          st_d     = ST_WAIT_LO;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TIMEOUT_W - 1);
        end else if (tmr_zero) begin
          st_d    = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (!busy_s) begin
          st_d     = ST_RD_HI;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(STROBE_W - 1);
        end else if (tmr_zero) begin
          st_d    = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_RD_HI: begin
        if (tmr_zero) begin
          if (mode_q) begin
            fin8 = 1'b1;
            st_d = ST_DONE;
          end else begin
            cap_hi   = 1'b1;
            st_d     = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(GAP_W - 1);
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          st_d     = ST_RD_LO;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(STROBE_W - 1);
        end
      end
      ST_RD_LO: begin
        if (tmr_zero) begin
          cap_lo = 1'b1;
          st_d   = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d     = ST_GUARD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(GUARD_W - 1);
      end
      ST_GUARD: begin
        if (tmr_zero) begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    strobe_d = (st_d == ST_RD_HI) || (st_d == ST_RD_LO);
    err_d    = err_q;
    if (err_set) begin
      err_d = 1'b1;
    end else if (err_clr) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= mode8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      conv_n_q <= 1'b1;
      cs_n_q   <= 1'b1;
      rd_n_q   <= 1'b1;
    end else begin
      err_q    <= err_d;
      conv_n_q <= (st_d != ST_START);
      cs_n_q   <= !strobe_d;
      rd_n_q   <= !strobe_d;
    end
  end

  assign conv_n      = conv_n_q;
  assign cs_n        = cs_n_q;
  assign rd_n        = rd_n_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/adc_split_host.sv
module adc_split_host
  import adc_host_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int LOW_W       = 2,
  parameter int START_W     = 3,
  parameter int STROBE_W    = 4,
  parameter int GAP_W       = 2,
  parameter int GUARD_W     = 10,
  parameter int TIMEOUT_W   = 200,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = BUS_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             mode8,
  input  logic             busy_in,
  input  logic [BUS_W-1:0] data_in,
  output logic             conv_n,
  output logic             cs_n,
  output logic             rd_n,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             timeout_err
);

  localparam int unsigned MAX_W = max_of5(START_W, STROBE_W, GAP_W, GUARD_W, TIMEOUT_W);
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic             rst_meta_q, rst_sn_q;
  logic             busy_s;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             cap_hi, cap_lo, fin8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn_q   <= rst_meta_q;
    end
  end

  adc_host_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk   (clk),
    .rst_n (rst_sn_q),
    .d     (busy_in),
    .q     (busy_s)
  );

  adc_host_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sn_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  adc_host_fsm #(
    .START_W   (START_W),
    .STROBE_W  (STROBE_W),
    .GAP_W     (GAP_W),
    .GUARD_W   (GUARD_W),
    .TIMEOUT_W (TIMEOUT_W),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sn_q),
    .start_req   (start_req),
    .mode8       (mode8),
    .busy_s      (busy_s),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cap_hi      (cap_hi),
    .cap_lo      (cap_lo),
    .fin8        (fin8),
    .conv_n      (conv_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .timeout_err (timeout_err)
  );

  adc_host_asm #(.BUS_W(BUS_W), .LOW_W(LOW_W)) u_asm (
    .clk     (clk),
    .rst_n   (rst_sn_q),
    .cap_hi  (cap_hi),
    .cap_lo  (cap_lo),
    .fin8    (fin8),
    .data_in (data_in),
    .result  (result),
    .valid   (result_valid)
  );

endmodule

// File: rtl/adc_split_host_chk.sv
module adc_split_host_chk #(
  parameter int STROBE_W = 4,
  parameter int GUARD_W  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic busy_in,
  input logic conv_n,
  input logic cs_n,
  input logic rd_n,
  input logic result_valid,
  input logic timeout_err
);

  int unsigned low_cnt_q;
  int unsigned since_rd_q;
  logic        seen_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q  <= 0;
      since_rd_q <= 0;
      seen_rd_q  <= 1'b0;
    end else begin
      if (!rd_n) begin
        low_cnt_q  <= (low_cnt_q < 1000) ? low_cnt_q + 1 : low_cnt_q;
        since_rd_q <= 0;
        seen_rd_q  <= 1'b1;
      end else begin
        low_cnt_q  <= 0;
        since_rd_q <= (since_rd_q < 100000) ? since_rd_q + 1 : since_rd_q;
      end
    end
  end

  // R2
  conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_n |-> (cs_n && rd_n));

  // R3
  no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !busy_in);

  // R4
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n == rd_n);

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (low_cnt_q == STROBE_W));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (rd_n && $rose(rd_n)));

  // R8
  guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_n) && seen_rd_q) |-> (since_rd_q >= GUARD_W + 1));

  // R9
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (rd_n && !result_valid));

endmodule

bind adc_split_host adc_split_host_chk #(
  .STROBE_W (STROBE_W),
  .GUARD_W  (GUARD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_in      (busy_in),
  .conv_n       (conv_n),
  .cs_n         (cs_n),
  .rd_n         (rd_n),
  .result_valid (result_valid),
  .timeout_err  (timeout_err)
);

// File: tb/sim_adc_split_host.sv
`timescale 1ns/1ps
module sim_adc_split_host;

  localparam int START_W   = 3;
  localparam int STROBE_W  = 4;
  localparam int GAP_W     = 2;
  localparam int GUARD_W   = 5;
  localparam int TIMEOUT_W = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic       mode8 = 1'b0;
  logic       busy_in = 1'b0;
  logic [7:0] data_in;
  logic       conv_n, cs_n, rd_n, result_valid, timeout_err;
  logic [9:0] result;

  int checks = 0;
  int fails  = 0;

  // converter model controls
  logic       bz_en = 1'b1;
  int         bz_dly = 2;
  int         bz_len = 6;
  logic [7:0] msb_m = 8'h00;
  logic [7:0] lsb_m = 8'h00;
  logic       phase = 1'b0;

  // monitor state
  int n_strobe = 0, n_valid = 0, n_conv = 0;
  int lo_cnt = 0, hi_cnt = 0, last_w = 0, prev_w = 0, last_gap = 0;
  int cv_cnt = 0, conv_w = 0, since_rd = 0, guard_gap = 0;
  int rd_busy_viol = 0;
  logic [9:0] cap_res = '0;
  logic prev_rd = 1'b1, prev_conv = 1'b1;

  always #5 clk = ~clk;

  adc_split_host #(
    .START_W   (START_W),
    .STROBE_W  (STROBE_W),
    .GAP_W     (GAP_W),
    .GUARD_W   (GUARD_W),
    .TIMEOUT_W (TIMEOUT_W)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .mode8        (mode8),
    .busy_in      (busy_in),
    .data_in      (data_in),
    .conv_n       (conv_n),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .result       (result),
    .result_valid (result_valid),
    .timeout_err  (timeout_err)
  );

  // Converter bus model: upper byte first, then low bits; order restarts on busy rise
  assign data_in = (!cs_n && !rd_n) ? (phase ? lsb_m : msb_m) : 8'hC3;

  always @(posedge rd_n or posedge busy_in) begin
    if (busy_in) phase <= 1'b0;
    else         phase <= ~phase;
  end

  always begin
    @(negedge conv_n);
    if (bz_en) begin
      repeat (bz_dly) @(negedge clk);
      busy_in = 1'b1;
      repeat (bz_len) @(negedge clk);
      busy_in = 1'b0;
    end
  end

  // Port monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rd_n && busy_in) rd_busy_viol++;
      if (result_valid) begin
        n_valid++;
        cap_res = result;
      end
      if (!rd_n) begin
        if (prev_rd) begin
          last_gap = hi_cnt;
          lo_cnt = 0;
        end
        lo_cnt++;
      end else begin
        if (!prev_rd) begin
          prev_w = last_w;
          last_w = lo_cnt;
          n_strobe++;
          hi_cnt = 0;
        end
        hi_cnt++;
      end
      if (!conv_n && prev_conv) begin
        guard_gap = since_rd;
        n_conv++;
        cv_cnt = 0;
      end
      if (!conv_n) cv_cnt++;
      if (conv_n && !prev_conv) conv_w = cv_cnt;
      if (!rd_n) since_rd = 0;
      else if (conv_n) since_rd++;
      prev_rd = rd_n;
      prev_conv = conv_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pulse_start(input logic m8);
    @(negedge clk);
    mode8 = m8;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    chk("R1 conv_n", int'(conv_n), 1);
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 rd_n", int'(rd_n), 1);
    chk("R1 valid", int'(result_valid), 0);
    chk("R1 err", int'(timeout_err), 0);
  endtask

  // R2 R3 R4 R5 R6 R9(clear)
  task automatic t_full(input logic [7:0] hi, input logic [7:0] lo);
    int s0, v0;
    s0 = n_strobe; v0 = n_valid;
    msb_m = hi; lsb_m = lo;
    bz_en = 1'b1; bz_dly = 2; bz_len = 6;
    pulse_start(1'b0);
    chk("R9 err cleared on start", int'(timeout_err), 0);
    repeat (70) @(negedge clk);
    chk("R2 conv width", conv_w, START_W);
    chk("R4 read count", n_strobe - s0, 2);
    chk("R4 first strobe width", prev_w, STROBE_W);
    chk("R4 second strobe width", last_w, STROBE_W);
    chk("R4 inter-read gap", last_gap, GAP_W);
    chk("R3 read while busy", rd_busy_viol, 0);
    chk("R6 valid count", n_valid - v0, 1);
    chk("R5 result", int'(cap_res), int'({hi, lo[7:6]}));
  endtask

  // R7
  task automatic t_mode8(input logic [7:0] hi);
    int s0, v0;
    s0 = n_strobe; v0 = n_valid;
    msb_m = hi; lsb_m = 8'hFF;
    bz_en = 1'b1; bz_dly = 1; bz_len = 4;
    pulse_start(1'b1);
    repeat (60) @(negedge clk);
    chk("R7 single read", n_strobe - s0, 1);
    chk("R7 valid count", n_valid - v0, 1);
    chk("R7 result", int'(cap_res), int'({hi, 2'b00}));
  endtask

  // R8
  task automatic t_guard();
    int c0, v0, wd;
    c0 = n_conv; v0 = n_valid;
    msb_m = 8'h3C; lsb_m = 8'h80;
    bz_en = 1'b1; bz_dly = 2; bz_len = 5;
    @(negedge clk);
    mode8 = 1'b0;
    start_req = 1'b1;
    wd = 0;
    while (n_conv - c0 < 2 && wd < 300) begin
      @(negedge clk);
      wd++;
    end
    chk("R8 held start gives one pulse per conversion", n_valid - v0, 1);
    chk("R8 guard gap", guard_gap, GUARD_W + 2);
    start_req = 1'b0;
    repeat (70) @(negedge clk);
    chk("R8 second result", int'(cap_res), int'({8'h3C, 2'b10}));
    chk("R8 conversions", n_conv - c0, 2);
  endtask

  // R9
  task automatic t_timeout_hi();
    int s0, v0;
    s0 = n_strobe; v0 = n_valid;
    bz_en = 1'b0;
    pulse_start(1'b0);
    repeat (TIMEOUT_W + 20) @(negedge clk);
    chk("R9 err after missing busy", int'(timeout_err), 1);
    chk("R9 no read", n_strobe - s0, 0);
    chk("R9 no valid", n_valid - v0, 0);
    bz_en = 1'b1;
  endtask

  // R9
  task automatic t_timeout_lo();
    int s0, v0;
    s0 = n_strobe; v0 = n_valid;
    bz_en = 1'b1; bz_dly = 2; bz_len = TIMEOUT_W + 30;
    pulse_start(1'b0);
    repeat (TIMEOUT_W + 60) @(negedge clk);
    chk("R9 err after stuck busy", int'(timeout_err), 1);
    chk("R9 no read stuck", n_strobe - s0, 0);
    chk("R9 no valid stuck", n_valid - v0, 0);
    chk("R9 busy low again", int'(busy_in), 0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 conv_n in reset", int'(conv_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full(8'hA5, 8'h40);
    t_full(8'h5A, 8'hBF);
    t_full(8'hFF, 8'hC0);
    t_mode8(8'h96);
    t_full(8'h12, 8'h7E);
    t_guard();
    t_timeout_hi();
    t_full(8'h01, 8'h2A);
    t_timeout_lo();
    t_full(8'h80, 8'hD5);
    finish_sim();
  end

endmodule